// File: doc/BRIEF.md
# Weight-Selective Cell Array Drive Sequencer

This block generates every digital drive signal for a small array of charge-storage cells. Each cell has a private input strobe, which loads a new sample, and a private transfer strobe, which moves its packet between two shared electrodes. One of the shared electrodes can be cut off from its driver by a switch, so that it floats and senses the total charge moved under it. The sequencer runs a fixed read cycle over and over. The cycle has these steps:

1. Every packet is pulled back under the second electrode.
2. The first electrode is set to its read level and then floated.
3. Only the cells whose weight is 1 are pulsed while the electrode floats, so the floating voltage gives a weighted sum.
4. The electrode is reconnected and the remaining cells are pulsed, so every packet ends the cycle in the same place.
5. The first electrode returns to its mid level, and one addressed cell may be reloaded.

Two register chains move forward by one step at the end of every read cycle. A one-hot pointer picks the cell that may be reloaded. A weight chain takes one serial weight bit per cycle into cell 0 and moves the older bits toward higher cell numbers. The weight pattern therefore slides past the stored samples, and the array acts as a correlator. Every output is registered, so each output follows the internal phase by one clock.

Top module: `cell_drive_seq`

## Requirements
- R1: While reset is high, and after it is released until the first phase output, all input and transfer strobes are low, the sense strobe and second-electrode drive are low, the float switch is closed (`sw_on_o`=1), and the first electrode level is mid (`ph1_o`=2'b01).
- R2: The reload pointer starts at cell 0 in the first read cycle after reset and moves to the next cell (bit i to bit i+1, wrapping from the last cell to 0) once per cycle. An input strobe only ever addresses the pointed cell (bit i of `ig_o` = cell i), and at most one input strobe is high at a time.
- R3: An input strobe is issued for PULSE_T clocks, in the reload slot of a cycle, only if `upd_i` was high at the last clock of that cycle's rest phase. Otherwise no input strobe appears in that cycle.
- R4: Each cycle opens with transfer pulse 1 on every cell for PULSE_T clocks, with the second electrode driven (`ph2_o`=1) and the first electrode at mid level.
- R5: The first electrode is at read level (`ph1_o`=2'b10) for SETTLE_T clocks with the switch still closed before the switch opens. The switch then stays open for FLOAT_T clocks.
- R6: During the float window, transfer pulse 2 covers exactly the cells whose current weight bit is 1 (bit i of `tg_o` = cell i), for PULSE_T clocks.
- R7: After the switch closes again, with the first electrode still at read level and the second electrode released, transfer pulse 3 covers exactly the cells whose weight bit is 0, for PULSE_T clocks. The first electrode then returns to mid level.
- R8: The sense strobe is high for exactly one clock per cycle: the last clock of the float window.
- R9: At the end of each cycle, `wbit_i` enters cell 0 of the weight chain and each cell i passes its bit to cell i+1. The bit presented during cycle k is therefore the weight of cell j in cycle k+1+j. Reset clears all weights.
- R10: Input strobes never coincide with any transfer strobe, and are issued only while the switch is closed, the first electrode is at mid level and the second electrode is released.
- R11: A read cycle lasts exactly 3*PULSE_T + 2*SETTLE_T + FLOAT_T clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| wbit_i | input | 1 | Serial weight bit, taken at the end of each read cycle |
| upd_i | input | 1 | Reload request, sampled at the end of the rest phase |
| ig_o | output | N_CELLS | Per-cell input strobes |
| tg_o | output | N_CELLS | Per-cell transfer strobes |
| ph1_o | output | 2 | First electrode level: 01 mid, 10 read |
| ph2_o | output | 1 | Second electrode drive, high while it holds packets |
| sw_on_o | output | 1 | Float switch, high = electrode connected to driver |
| sense_o | output | 1 | Sense-valid strobe, last clock of the float window |

## Verification
The hardest situation to reach is one that shows a weight bit was captured in the right cycle and moved to the right cell. A bit given in cycle k only shows up in the float-window mask many cycles later, and it moves one cell per cycle. The stimulus therefore drives an irregular serial pattern, including a long run of ones, so that both an empty pulse-2 mask and an empty pulse-3 mask occur. It also switches the reload request on and off, sometimes in the same cycle that the pointer wraps. The scoreboard rebuilds the weight chain and the pointer from the requirements and compares each cycle's masks and phase lengths.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;

  typedef enum logic [2:0] {
    PH_PULL  = 3'd0,
    PH_ARM   = 3'd1,
    PH_FLOAT = 3'd2,
    PH_PUSH  = 3'd3,
    PH_REST  = 3'd4,
    PH_LOAD  = 3'd5
  } seq_phase_e;

  typedef enum logic [1:0] {
    LVL_OFF  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_READ = 2'b10
  } elec_lvl_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/seq_phase_timer.sv
module seq_phase_timer
  import chg_seq_pkg::*;
#(
  parameter int PULSE_T  = 4,
  parameter int SETTLE_T = 2,
  parameter int FLOAT_T  = 6,
  parameter int CW       = 3
) (
  input  logic          clk,
  input  logic          rst,
  output seq_phase_e    phase_o,
  output logic [CW-1:0] cnt_o,
  output logic          last_o,
  output logic          cycle_end_o
);

  seq_phase_e    phase_q, phase_d;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] dur_m1;
  logic          last;

  always_comb begin
    case (phase_q)
      PH_PULL:  dur_m1 = CW'(PULSE_T - 1);
      PH_ARM:   dur_m1 = CW'(SETTLE_T - 1);
      PH_FLOAT: dur_m1 = CW'(FLOAT_T - 1);
      PH_PUSH:  dur_m1 = CW'(PULSE_T - 1);
      PH_REST:  dur_m1 = CW'(SETTLE_T - 1);
      PH_LOAD:  dur_m1 = CW'(PULSE_T - 1);
      default:  dur_m1 = '0;
    endcase
  end

  assign last = (cnt_q == dur_m1);

  always_comb begin
    case (phase_q)
      PH_PULL:  phase_d = PH_ARM;
      PH_ARM:   phase_d = PH_FLOAT;
      PH_FLOAT: phase_d = PH_PUSH;
      PH_PUSH:  phase_d = PH_REST;
      PH_REST:  phase_d = PH_LOAD;
      PH_LOAD:  phase_d = PH_PULL;
      default:  phase_d = PH_PULL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_PULL;
      cnt_q   <= '0;
    end else if (last) begin
      phase_q <= phase_d;
      cnt_q   <= '0;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign phase_o     = phase_q;
  assign cnt_o       = cnt_q;
  assign last_o      = last;
  assign cycle_end_o = last && (phase_q == PH_LOAD);

endmodule

// File: rtl/cell_ptr_ring.sv
module cell_ptr_ring #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_i,
  output logic [N-1:0] ptr_o
);

  logic [N-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst)
      ptr_q <= N'(1);
    else if (step_i)
      ptr_q <= {ptr_q[N-2:0], ptr_q[N-1]};
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/weight_chain.sv
module weight_chain #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_i,
  input  logic         din_i,
  output logic [N-1:0] wgt_o
);

  logic [N-1:0] wgt_q;

  always_ff @(posedge clk) begin
    if (rst)
      wgt_q <= '0;
    else if (step_i)
      wgt_q <= {wgt_q[N-2:0], din_i};
  end

  assign wgt_o = wgt_q;

endmodule

// File: rtl/strobe_out.sv
module strobe_out
  import chg_seq_pkg::*;
#(
  parameter int N       = 8,
  parameter int PULSE_T = 4,
  parameter int CW      = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  seq_phase_e    phase_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          last_i,
  input  logic [N-1:0]  ptr_i,
  input  logic [N-1:0]  wgt_i,
  input  logic          upd_arm_i,
  output logic [N-1:0]  ig_o,
  output logic [N-1:0]  tg_o,
  output logic [1:0]    ph1_o,
  output logic          ph2_o,
  output logic          sw_on_o,
  output logic          sense_o
);

  localparam logic [CW-1:0] P2_LIM = CW'(PULSE_T);

  logic [N-1:0] ig_d, tg_d;
  logic         in_pull, in_float, in_push, in_load, p2_win;
  elec_lvl_e    ph1_d;

  assign in_pull  = (phase_i == PH_PULL);
  assign in_float = (phase_i == PH_FLOAT);
  assign in_push  = (phase_i == PH_PUSH);
  assign in_load  = (phase_i == PH_LOAD);
  assign p2_win   = in_float && (cnt_i < P2_LIM);

  for (genvar i = 0; i < N; i++) begin : g_cell
    assign tg_d[i] = in_pull || (p2_win && wgt_i[i]) || (in_push && !wgt_i[i]);
    assign ig_d[i] = in_load && upd_arm_i && ptr_i[i];
  end

  always_comb begin
    case (phase_i)
      PH_ARM, PH_FLOAT, PH_PUSH: ph1_d = LVL_READ;
      default:                   ph1_d = LVL_MID;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ig_o    <= '0;
      tg_o    <= '0;
      ph1_o   <= LVL_MID;
      ph2_o   <= 1'b0;
      sw_on_o <= 1'b1;
      sense_o <= 1'b0;
    end else begin
      ig_o    <= ig_d;
      tg_o    <= tg_d;
      ph1_o   <= ph1_d;
      ph2_o   <= in_pull || (phase_i == PH_ARM) || in_float;
      sw_on_o <= !in_float;
      sense_o <= in_float && last_i;
    end
  end

endmodule

// File: rtl/cell_drive_seq.sv
module cell_drive_seq
  import chg_seq_pkg::*;
#(
  parameter int N_CELLS  = 8,
  parameter int PULSE_T  = 4,
  parameter int SETTLE_T = 2,
  parameter int FLOAT_T  = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wbit_i,
  input  logic               upd_i,
  output logic [N_CELLS-1:0] ig_o,
  output logic [N_CELLS-1:0] tg_o,
  output logic [1:0]         ph1_o,
  output logic               ph2_o,
  output logic               sw_on_o,
  output logic               sense_o
);

  localparam int MAX_T = max3(PULSE_T, SETTLE_T, FLOAT_T);
  localparam int CW    = $clog2(MAX_T + 1);

  seq_phase_e         phase;
  logic [CW-1:0]      cnt;
  logic               last, cycle_end;
  logic [N_CELLS-1:0] ptr, wgt;
  logic               upd_arm_q;

  seq_phase_timer #(
    .PULSE_T(PULSE_T), .SETTLE_T(SETTLE_T), .FLOAT_T(FLOAT_T), .CW(CW)
  ) u_timer (
    .clk(clk), .rst(rst), .phase_o(phase), .cnt_o(cnt),
    .last_o(last), .cycle_end_o(cycle_end)
  );

  cell_ptr_ring #(.N(N_CELLS)) u_ptr (
    .clk(clk), .rst(rst), .step_i(cycle_end), .ptr_o(ptr)
  );

  weight_chain #(.N(N_CELLS)) u_wgt (
    .clk(clk), .rst(rst), .step_i(cycle_end), .din_i(wbit_i), .wgt_o(wgt)
  );

  always_ff @(posedge clk) begin
    if (rst)
      upd_arm_q <= 1'b0;
    else if (last && (phase == PH_REST))
      upd_arm_q <= upd_i;
  end

  strobe_out #(.N(N_CELLS), .PULSE_T(PULSE_T), .CW(CW)) u_out (
    .clk(clk), .rst(rst), .phase_i(phase), .cnt_i(cnt), .last_i(last),
    .ptr_i(ptr), .wgt_i(wgt), .upd_arm_i(upd_arm_q),
    .ig_o(ig_o), .tg_o(tg_o), .ph1_o(ph1_o), .ph2_o(ph2_o),
    .sw_on_o(sw_on_o), .sense_o(sense_o)
  );

endmodule

// File: rtl/cell_drive_seq_chk.sv
module cell_drive_seq_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] ig_o,
  input logic [N-1:0] tg_o,
  input logic [1:0]   ph1_o,
  input logic         ph2_o,
  input logic         sw_on_o,
  input logic         sense_o
);

  localparam logic [1:0] MID  = 2'b01;
  localparam logic [1:0] READ = 2'b10;

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (ig_o == '0 && tg_o == '0 && sw_on_o && !sense_o && !ph2_o && ph1_o == MID));

  p_ig_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ig_o));

  p_pull_all_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ph2_o) |-> (tg_o == '1 && ph1_o == MID));

  p_float_entry_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(sw_on_o) |-> (ph1_o == READ && $past(ph1_o) == READ));

  p_float_level_r6: assert property (@(posedge clk) disable iff (rst)
    !sw_on_o |-> (ph1_o == READ && ph2_o));

  p_reconnect_read_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(sw_on_o) |-> (ph1_o == READ && !ph2_o));

  p_sense_float_r8: assert property (@(posedge clk) disable iff (rst)
    sense_o |-> !sw_on_o);

  p_sense_last_r8: assert property (@(posedge clk) disable iff (rst)
    sense_o |=> sw_on_o);

  p_ig_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (ig_o != '0) |-> (tg_o == '0 && sw_on_o && ph1_o == MID && !ph2_o));

endmodule

bind cell_drive_seq cell_drive_seq_chk #(.N(N_CELLS)) u_chk (
  .clk(clk), .rst(rst), .ig_o(ig_o), .tg_o(tg_o), .ph1_o(ph1_o),
  .ph2_o(ph2_o), .sw_on_o(sw_on_o), .sense_o(sense_o)
);

// File: tb/sim_cell_drive_seq.sv
`timescale 1ns/1ps
module sim_cell_drive_seq;

  localparam int N    = 8;
  localparam int PT   = 4;
  localparam int ST   = 2;
  localparam int FT   = 6;
  localparam int CYC  = 3*PT + 2*ST + FT;
  localparam int NCYC = 40;

  typedef struct {
    logic [N-1:0] p1, p2, p3, ig;
    int p1_n, arm_n, float_n, p2_n, p3_n, ig_n, sense_n, len;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wbit = 1'b0;
  logic upd = 1'b0;
  logic [N-1:0] ig, tg;
  logic [1:0] ph1;
  logic ph2, sw_on, sense;

  int checks = 0;
  int errs = 0;
  int cyc_started = 0;
  bit done = 0;
  item_t exp_q[$];

  always #5 clk = ~clk;

  cell_drive_seq #(.N_CELLS(N), .PULSE_T(PT), .SETTLE_T(ST), .FLOAT_T(FT)) u0 (
    .clk(clk), .rst(rst), .wbit_i(wbit), .upd_i(upd),
    .ig_o(ig), .tg_o(tg), .ph1_o(ph1), .ph2_o(ph2),
    .sw_on_o(sw_on), .sense_o(sense)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  // monitor: assemble one observed item per read cycle and compare
  item_t obs;
  bit have = 0;
  bit prev_ph2 = 0;

  always @(negedge clk) begin
    if (rst) begin
      have = 0;
      prev_ph2 = 0;
    end else begin
      if (ph2 && !prev_ph2) begin
        if (have) begin
          item_t e;
          if (exp_q.size() == 0) begin
            chk(0, "R11 unexpected cycle", 0, 1);
          end else begin
            e = exp_q.pop_front();
            chk(obs.p1 == e.p1, "R4 pulse1 mask", int'(obs.p1), int'(e.p1));
            chk(obs.p1_n == e.p1_n, "R4 pulse1 width", obs.p1_n, e.p1_n);
            chk(obs.arm_n == e.arm_n, "R5 read level before float", obs.arm_n, e.arm_n);
            chk(obs.float_n == e.float_n, "R5 float length", obs.float_n, e.float_n);
            chk(obs.p2 == e.p2, "R6 R9 pulse2 mask", int'(obs.p2), int'(e.p2));
            chk(obs.p2_n == e.p2_n, "R6 pulse2 width", obs.p2_n, e.p2_n);
            chk(obs.p3 == e.p3, "R7 R9 pulse3 mask", int'(obs.p3), int'(e.p3));
            chk(obs.p3_n == e.p3_n, "R7 pulse3 width", obs.p3_n, e.p3_n);
            chk(obs.ig == e.ig, "R2 R3 input strobe mask", int'(obs.ig), int'(e.ig));
            chk(obs.ig_n == e.ig_n, "R3 R10 input strobe width", obs.ig_n, e.ig_n);
            chk(obs.sense_n == e.sense_n, "R8 sense count", obs.sense_n, e.sense_n);
            chk(obs.len == e.len, "R11 cycle length", obs.len, e.len);
          end
        end
        obs = '{default: 0};
        have = 1;
        cyc_started++;
      end
      if (have) begin
        obs.len++;
        if (ph2 && sw_on && ph1 == 2'b01 && tg != '0) begin
          obs.p1 |= tg; obs.p1_n++;
        end
        if (ph2 && sw_on && ph1 == 2'b10) begin
          obs.arm_n++;
          if (tg != '0) chk(0, "R5 no transfer while arming", int'(tg), 0);
        end
        if (!sw_on) begin
          obs.float_n++;
          if (tg != '0) begin obs.p2 |= tg; obs.p2_n++; end
        end
        if (sw_on && !ph2 && ph1 == 2'b10 && tg != '0) begin
          obs.p3 |= tg; obs.p3_n++;
        end
        if (ig != '0) begin
          obs.ig |= ig;
          if (sw_on && !ph2 && ph1 == 2'b01 && tg == '0) obs.ig_n++;
        end
        if (sense) obs.sense_n++;
      end
      prev_ph2 = ph2;
    end
  end

  // driver: model of weights and pointer from the requirements
  initial begin
    logic [N-1:0] w_m;
    logic [N-1:0] p_m;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ig == '0 && tg == '0, "R1 strobes low in reset", int'({ig, tg}), 0);
    chk(sw_on && !sense && !ph2, "R1 switch closed, sense low", int'({sw_on, sense, ph2}), 4);
    chk(ph1 == 2'b01, "R1 first electrode mid", int'(ph1), 1);
    @(negedge clk);
    rst = 1'b0;
    w_m = '0;
    p_m = N'(1);
    for (int k = 0; k < NCYC; k++) begin
      item_t e;
      bit b, u;
      wait (cyc_started > k);
      if (k >= 18 && k < 30) b = 1'b1;
      else b = (((k * 5 + 3) % 7) < 3);
      u = (k % 3 != 1);
      e.p1 = '1;       e.p1_n = PT;
      e.arm_n = ST;    e.float_n = FT;
      e.p2 = w_m;      e.p2_n = (w_m != '0) ? PT : 0;
      e.p3 = ~w_m;     e.p3_n = (~w_m != '0) ? PT : 0;
      e.ig = u ? p_m : '0;
      e.ig_n = u ? PT : 0;
      e.sense_n = 1;
      e.len = CYC;
      exp_q.push_back(e);
      wbit = b;
      upd = u;
      w_m = {w_m[N-2:0], b};
      p_m = {p_m[N-2:0], p_m[N-1]};
    end
    wait (cyc_started > NCYC);
    @(negedge clk);
    chk(exp_q.size() == 0, "R11 all cycles seen", exp_q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog R11 actual=%0d expected=%0d", cyc_started, NCYC + 1);
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end

endmodule